// File: doc/BRIEF.md
# EDO DRAM Device Model

This block is a synthesizable stand-in for an asynchronous extended-data-out DRAM with a 16-bit data bus. It is meant to sit in a testbench as the target of a memory controller under test. The controller drives a multiplexed address bus and active-low strobes: a row strobe, two byte-lane column strobes, a write enable and an output enable. The data bus is split into an input word, an output word and one output-enable bit per byte lane.

All strobes are sampled on the rising edge of a fast model clock. Edges are found by comparing each sample with the one before it. Outputs are registered, so they reflect the inputs sampled at the same edge and are visible just after it. The array is shrunk through the row and column width parameters. Storage is plain and never decays. Refresh cycles are recognised and advance an internal 10-bit row counter, but they never disturb stored data.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, neither byte lane is driven (`dq_oe` = 2'b00).
- R2: The row is taken from `addr` at the sample where `ras_n` is first seen low. The column is taken at the sample where the merged column strobe is first seen low. Later changes on `addr` within that strobe period have no effect on what is read or written.
- R3: The merged column strobe is low while either `lcas_n` or `ucas_n` is low. Only the first lane strobe to fall latches the column; a second lane falling later reuses that column.
- R4: `lcas_n` controls bits 7:0 and `dq_oe[0]`. `ucas_n` controls bits 15:8 and `dq_oe[1]`. A write changes only the lanes whose strobe is low.
- R5: At each sample where a normal row is open, the merged column strobe is low, `we_n` is high and `oe_n` is low, `dq_out` takes the stored word and `dq_oe` takes the low lane strobes. Both are visible one clock later.
- R6: Write data is the value of `dq_in` at the earlier falling edge of the merged column strobe or `we_n`. The write itself happens once both are low (early write or late write).
- R7: After a read, when the column strobes rise, `dq_out` and `dq_oe` keep their values. This holds even after `ras_n` rises, until the next column strobe fall. At that fall, the data of the newly latched column appears.
- R8: `dq_oe` returns to 2'b00 one clock after any sample with `oe_n` high or `we_n` low.
- R9: If the merged column strobe is already low when `ras_n` falls, the cycle is refresh-only. Nothing is driven, nothing is written, `addr` is ignored, and an internal 10-bit row counter advances by one (mod 1024). The cycle ends once `ras_n` and both column strobes are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Multiplexed row/column address |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Low-byte column strobe, active low |
| ucas_n | input | 1 | High-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_in | input | 16 | Write data from the controller |
| dq_out | output | 16 | Read data to the controller |
| dq_oe | output | 2 | Per-lane drive enable (bit 0 = 7:0, bit 1 = 15:8) |

## Verification
The hardest states to reach are the orderings within one column strobe period. These are a late write, where the data was taken at the column strobe fall rather than at the write-enable fall, and a split byte-lane fall with the address bus changing in between. Directed tasks place each strobe and address change on a chosen clock. The bus value is then altered after the capture point, so a wrong capture shows up as a different word on readback. EDO hold is reached by a read whose column strobe rises while output enable stays low. It is then observed across a page step and across the row strobe rising.

// File: rtl/edo_pkg.sv
package edo_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DQ_W   = LANE_W * LANES;

    typedef logic [LANES-1:0] lane_t;

    typedef struct packed {
        logic ras_fall;
        logic cas_fall;
        logic cas_rise;
        logic we_fall;
    } strobe_ev_t;

    // merged column strobe: low while any lane strobe is low
    function automatic logic merge_cas(input lane_t lane_n);
        return &lane_n;
    endfunction
endpackage

// File: rtl/edo_strobe_det.sv
module edo_strobe_det
    import edo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ras_n,
    input  lane_t      lane_n,
    input  logic       we_n,
    output logic       cas_n,
    output strobe_ev_t ev
);
    logic ras_q, cas_q, we_q;

    assign cas_n = merge_cas(lane_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    always_comb begin
        ev.ras_fall = ras_q & ~ras_n;
        ev.cas_fall = cas_q & ~cas_n;
        ev.cas_rise = ~cas_q & cas_n;
        ev.we_fall  = we_q & ~we_n;
    end
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
    parameter int REF_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [REF_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/edo_array.sv
module edo_array
    import edo_pkg::*;
#(
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic            clk,
    input  lane_t           wr_lane,
    input  logic [AW-1:0]   waddr,
    input  logic [DQ_W-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [DQ_W-1:0] rdata
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_lane[k]) mem[waddr] <= wdata[k*LANE_W +: LANE_W];
        end
        assign rdata[k*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
    import edo_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int REF_W = 10,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int AW     = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic [LANES-1:0]  dq_oe
);
    lane_t             lane_n;
    logic              cas_n;
    strobe_ev_t        ev;
    logic              row_open, cbr_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q, col_eff;
    logic              wcap;
    logic [DQ_W-1:0]   wdata_q, wsrc, rdata;
    lane_t             wdone, wr_lane;
    logic              rd_act, wr_ok, hold_ok, ref_inc;
    logic [REF_W-1:0]  ref_cnt;

    assign lane_n = {ucas_n, lcas_n};

    edo_strobe_det u_det (
        .clk(clk), .rst(rst), .ras_n(ras_n), .lane_n(lane_n),
        .we_n(we_n), .cas_n(cas_n), .ev(ev)
    );

    assign ref_inc = ev.ras_fall & ~cas_n;

    edo_refresh_ctr #(.REF_W(REF_W)) u_ref (
        .clk(clk), .rst(rst), .inc(ref_inc), .cnt(ref_cnt)
    );

    always_comb begin
        col_eff = ev.cas_fall ? addr[COL_W-1:0] : col_q;
        rd_act  = row_open & ~cas_n & we_n & ~oe_n;
        wr_ok   = row_open & ~cas_n & ~we_n;
        wsrc    = wcap ? wdata_q : dq_in;
        hold_ok = (dq_oe != '0) & ~oe_n & we_n & ~ev.cas_fall & ~ev.ras_fall;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_wr
        assign wr_lane[k] = wr_ok & ~lane_n[k] & ~wdone[k];
    end

    edo_array #(.AW(AW)) u_arr (
        .clk(clk), .wr_lane(wr_lane), .waddr({row_q, col_eff}),
        .wdata(wsrc), .raddr({row_q, col_eff}), .rdata(rdata)
    );

    // row cycle tracking: normal vs refresh-only
    always_ff @(posedge clk) begin
        if (rst) begin
            row_open <= 1'b0;
            cbr_q    <= 1'b0;
            row_q    <= '0;
        end else if (ev.ras_fall) begin
            row_open <= cas_n;
            cbr_q    <= ~cas_n;
            row_q    <= addr[ROW_W-1:0];
        end else if (ras_n && cas_n) begin
            row_open <= 1'b0;
            cbr_q    <= 1'b0;
        end
    end

    // column latch and write data capture
    always_ff @(posedge clk) begin
        if (rst) begin
            col_q   <= '0;
            wcap    <= 1'b0;
            wdata_q <= '0;
            wdone   <= '0;
        end else begin
            if (ev.cas_fall) col_q <= addr[COL_W-1:0];
            if (ev.cas_rise) wcap <= 1'b0;
            else if ((ev.cas_fall || ev.we_fall) && !wcap) begin
                wcap    <= 1'b1;
                wdata_q <= dq_in;
            end
            wdone <= (wdone | wr_lane) & ~lane_n;
        end
    end

    // output register with EDO hold
    always_ff @(posedge clk) begin
        if (rst) begin
            dq_out <= '0;
            dq_oe  <= '0;
        end else if (rd_act) begin
            dq_out <= rdata;
            dq_oe  <= ~lane_n;
        end else if (!hold_ok) begin
            dq_oe  <= '0;
        end
    end
endmodule

// File: rtl/edo_dram_chk.sv
module edo_dram_chk
    import edo_pkg::*;
#(
    parameter int REF_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             lcas_n,
    input logic             ucas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [DQ_W-1:0]  dq_out,
    input logic [LANES-1:0] dq_oe,
    input logic             cbr_q,
    input logic [REF_W-1:0] ref_cnt
);
    // R4
    lo_lane_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe[0]) |-> !$past(lcas_n));
    // R4
    hi_lane_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe[1]) |-> !$past(ucas_n));
    // R7
    edo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lcas_n && ucas_n && dq_oe != '0) |=> $stable(dq_out));
    // R8
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> dq_oe == '0);
    // R8
    we_off_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> dq_oe == '0);
    // R9
    refresh_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        cbr_q |-> dq_oe == '0);
    // R9
    refresh_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cbr_q) |-> ref_cnt == REF_W'($past(ref_cnt) + 1'b1));
endmodule

bind edo_dram_model edo_dram_chk #(.REF_W(REF_W)) chk_i (
    .clk(clk), .rst(rst), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .cbr_q(cbr_q), .ref_cnt(ref_cnt)
);

// File: tb/edo_dram_model_tb.sv
module edo_dram_model_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1;
    logic        we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] rd;
    logic [1:0]  en;

    always #5 clk = ~clk;

    edo_dram_model dut_i (
        .clk(clk), .rst(rst), .addr(addr), .ras_n(ras_n), .lcas_n(lcas_n),
        .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic write_word(input logic [3:0] r, input logic [3:0] c,
                              input logic [15:0] d, input logic [1:0] lanes);
        addr = r; ras_n = 0; tick();
        addr = c; we_n = 0; dq_in = d; tick();
        lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; tick();
        lcas_n = 1; ucas_n = 1; we_n = 1; tick();
        ras_n = 1; tick(); tick();
    endtask

    task automatic read_word(input logic [3:0] r, input logic [3:0] c,
                             input logic [1:0] lanes, output logic [15:0] d,
                             output logic [1:0] e);
        addr = r; ras_n = 0; tick();
        addr = c; oe_n = 0; tick();
        lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; tick();
        d = dq_out; e = dq_oe;
        lcas_n = 1; ucas_n = 1; oe_n = 1; tick();
        ras_n = 1; tick(); tick();
    endtask

    task automatic t_reset();
        check(dq_oe == 2'b00, "R1 reset lanes", {14'd0, dq_oe}, 16'h0);
    endtask

    task automatic t_read_lanes();
        write_word(4'd2, 4'd5, 16'hA5C3, 2'b11);
        read_word(4'd2, 4'd5, 2'b11, rd, en);
        check(rd == 16'hA5C3, "R5 read data", rd, 16'hA5C3);
        check(en == 2'b11, "R5 read lanes", {14'd0, en}, 16'h3);
        write_word(4'd2, 4'd5, 16'h0011, 2'b01);
        read_word(4'd2, 4'd5, 2'b11, rd, en);
        check(rd == 16'hA511, "R4 low-lane write", rd, 16'hA511);
        read_word(4'd2, 4'd5, 2'b10, rd, en);
        check(en == 2'b10, "R4 upper-only enable", {14'd0, en}, 16'h2);
        check(rd[15:8] == 8'hA5, "R4 upper-only data", {8'h0, rd[15:8]}, 16'h00A5);
    endtask

    task automatic t_addr_latch();
        write_word(4'd1, 4'd1, 16'h1111, 2'b11);
        write_word(4'd1, 4'd2, 16'h2222, 2'b11);
        addr = 4'd1; ras_n = 0; tick();
        addr = 4'd1; we_n = 0; dq_in = 16'h3333; tick();
        lcas_n = 0; ucas_n = 0; tick();
        addr = 4'd2; dq_in = 16'h9999; tick();
        lcas_n = 1; ucas_n = 1; we_n = 1; tick();
        ras_n = 1; tick(); tick();
        read_word(4'd1, 4'd1, 2'b11, rd, en);
        check(rd == 16'h3333, "R2 latched column written", rd, 16'h3333);
        read_word(4'd1, 4'd2, 2'b11, rd, en);
        check(rd == 16'h2222, "R2 late address ignored", rd, 16'h2222);
    endtask

    task automatic t_cas_merge();
        addr = 4'd1; ras_n = 0; tick();
        addr = 4'd1; oe_n = 0; tick();
        lcas_n = 0; tick();
        addr = 4'd2; ucas_n = 0; tick();
        check(dq_out == 16'h3333, "R3 second lane keeps column", dq_out, 16'h3333);
        check(dq_oe == 2'b11, "R3 both lanes on", {14'd0, dq_oe}, 16'h3);
        lcas_n = 1; ucas_n = 1; oe_n = 1; tick();
        ras_n = 1; tick(); tick();
    endtask

    task automatic t_write_capture();
        addr = 4'd3; ras_n = 0; tick();
        addr = 4'd3; we_n = 0; dq_in = 16'h4444; tick();
        dq_in = 16'h5555; tick();
        lcas_n = 0; ucas_n = 0; tick();
        lcas_n = 1; ucas_n = 1; we_n = 1; tick();
        ras_n = 1; tick(); tick();
        read_word(4'd3, 4'd3, 2'b11, rd, en);
        check(rd == 16'h4444, "R6 early write data", rd, 16'h4444);
        addr = 4'd3; ras_n = 0; tick();
        addr = 4'd4; dq_in = 16'h6666; tick();
        lcas_n = 0; ucas_n = 0; tick();
        dq_in = 16'h7777; we_n = 0; tick();
        lcas_n = 1; ucas_n = 1; we_n = 1; tick();
        ras_n = 1; tick(); tick();
        read_word(4'd3, 4'd4, 2'b11, rd, en);
        check(rd == 16'h6666, "R6 late write data", rd, 16'h6666);
    endtask

    task automatic t_edo_hold();
        addr = 4'd1; ras_n = 0; tick();
        addr = 4'd1; oe_n = 0; tick();
        lcas_n = 0; ucas_n = 0; tick();
        lcas_n = 1; ucas_n = 1; tick();
        check(dq_oe == 2'b11 && dq_out == 16'h3333, "R7 hold after CAS rise",
              dq_out, 16'h3333);
        addr = 4'd2; tick();
        lcas_n = 0; ucas_n = 0; tick();
        check(dq_out == 16'h2222, "R7 page step new column", dq_out, 16'h2222);
        lcas_n = 1; ucas_n = 1; tick();
        ras_n = 1; tick();
        check(dq_oe == 2'b11 && dq_out == 16'h2222, "R7 hold past RAS rise",
              dq_out, 16'h2222);
        oe_n = 1; tick();
        check(dq_oe == 2'b00, "R8 OE high ends hold", {14'd0, dq_oe}, 16'h0);
        tick();
        addr = 4'd1; ras_n = 0; tick();
        addr = 4'd1; oe_n = 0; tick();
        lcas_n = 0; ucas_n = 0; tick();
        lcas_n = 1; ucas_n = 1; tick();
        we_n = 0; tick();
        check(dq_oe == 2'b00, "R8 WE low ends hold", {14'd0, dq_oe}, 16'h0);
        we_n = 1; oe_n = 1; ras_n = 1; tick(); tick();
    endtask

    task automatic t_refresh();
        lcas_n = 0; ucas_n = 0; tick();
        addr = 4'd1; oe_n = 0; we_n = 0; dq_in = 16'hDEAD; ras_n = 0; tick();
        check(dq_oe == 2'b00, "R9 refresh no drive", {14'd0, dq_oe}, 16'h0);
        tick();
        check(dq_oe == 2'b00, "R9 refresh still hi-z", {14'd0, dq_oe}, 16'h0);
        ras_n = 1; tick();
        lcas_n = 1; ucas_n = 1; tick();
        we_n = 1; oe_n = 1; tick(); tick();
        read_word(4'd1, 4'd1, 2'b11, rd, en);
        check(rd == 16'h3333, "R9 refresh no write col1", rd, 16'h3333);
        read_word(4'd1, 4'd2, 2'b11, rd, en);
        check(rd == 16'h2222, "R9 refresh no write col2", rd, 16'h2222);
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_read_lanes();
        t_addr_latch();
        t_cas_merge();
        t_write_capture();
        t_edo_hold();
        t_refresh();
        report();
    end
endmodule